// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

This block is a small, fully associative cache of page translations. It sits between a processor's address port and an external page-table walker. A lookup presents a virtual address and the current address-space identifier. All entries are compared at once, and on a hit the physical address is returned combinationally in the same cycle. The physical address is the cached frame number placed above the unchanged page offset.

Every entry carries the identifier of the address space that installed it. Translations from several processes can therefore live side by side. A hit requires both the virtual page number and the identifier to match.

On a miss the block stops accepting lookups and requests a walk from the external walker. When the walker answers, the block either installs the returned frame into the slot chosen by a round-robin pointer, or reports a fault for one cycle if the page-table entry is marked not present. A privileged side can drop every entry at once, or drop only the entries of one address space. Two free-running counters record hits and misses so that the hit ratio can be observed.

Top module: `xlat_cache`

## Requirements
- R1: When `lk_valid` and `lk_ready` are high and a valid entry holds the page number `lk_vaddr[31:12]` with the identifier `lk_asid`, `lk_hit` is high in that same cycle and `lk_paddr` equals `{frame, lk_vaddr[11:0]}`.
- R2: An entry whose page number matches but whose stored identifier differs from `lk_asid` does not produce a hit.
- R3: A lookup accepted with no matching entry raises `walk_req` from the next cycle, with `walk_vpn` and `walk_asid` holding the missed page number and identifier. `walk_req` stays high and `lk_ready` stays low until the cycle in which `walk_done` is sampled high.
- R4: A walker answer with `walk_pte_valid` = 1 installs `walk_pfn` for the missed page and identifier. In the cycle after `walk_done`, `lk_ready` is high and the same lookup hits with the new frame.
- R5: A walker answer with `walk_pte_valid` = 0 installs nothing and drives `lk_fault` high for exactly the one cycle after `walk_done`, with `lk_ready` low in that cycle. Repeating the lookup misses again.
- R6: Installs go to slots 0, 1, …, ENTRIES-1 in turn and then wrap to slot 0. Once the cache is full, a new install evicts the oldest installed translation.
- R7: A one-cycle pulse on `flush_all` invalidates every entry from the next cycle onward.
- R8: A one-cycle pulse on `flush_asid_en` invalidates only the entries whose identifier equals `flush_asid`. Entries of other identifiers still hit.
- R9: `hit_count` increments by one for every clock edge at which `lk_hit` is high. `miss_count` increments by one for every lookup that starts a walk. Both are 32 bits wide.
- R10: After reset the cache is empty: `lk_ready` = 1, `walk_req` = 0, `lk_fault` = 0, and both counters are 0.
- R11: When a flush and an install occur at the same clock edge, the flush wins. The new entry is invalid if the flush covers it, but the round-robin pointer still advances.
- R12: At most one entry matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address: {page number, offset} |
| lk_asid | input | ASID_W | Identifier of the current address space |
| lk_ready | output | 1 | Lookup accepted this cycle |
| lk_hit | output | 1 | Translation found (combinational) |
| lk_paddr | output | PFN_W+OFF_W | Physical address: {frame, offset} |
| lk_fault | output | 1 | One-cycle not-present fault |
| walk_req | output | 1 | Walk request level |
| walk_vpn | output | VPN_W | Page number to walk |
| walk_asid | output | ASID_W | Identifier to walk |
| walk_done | input | 1 | Walker answer strobe |
| walk_pte_valid | input | 1 | Answered page-table entry is present |
| walk_pfn | input | PFN_W | Answered frame number |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate entries of one identifier |
| flush_asid | input | ASID_W | Identifier to invalidate |
| hit_count | output | CNT_W | Hit counter |
| miss_count | output | CNT_W | Miss counter |

## Verification
The bench builds the cache with ENTRIES = 4 and keeps the default widths (20-bit page, 12-bit offset, 8-bit identifier, 20-bit frame). Four slots are enough to fill the cache, wrap the round-robin pointer and evict the oldest translation within a few dozen lookups. With that size the bench can also show eviction, identifier-selective flushing and a flush that coincides with an install, each in the same short run. The walker model derives every frame from the page number and identifier, and it marks pages with top nibble 0xF as not present, so fault and install paths both come up.

// File: rtl/xc_pkg.sv
package xc_pkg;

  typedef enum logic [0:0] {
    WS_IDLE = 1'b0,
    WS_WALK = 1'b1
  } walk_state_e;

endpackage

// File: rtl/xc_tag_array.sv
module xc_tag_array #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [ASID_W-1:0]  fill_asid,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic               flush_all,
  input  logic               flush_asid_en,
  input  logic [ASID_W-1:0]  flush_asid,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [PFN_W-1:0]   hit_pfn
);

  logic [PFN_W-1:0] pfn_pick [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic              v_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PFN_W-1:0]  pfn_q;
    logic              sel;
    logic [ASID_W-1:0] asid_now;
    logic              kill;

    assign sel      = fill_en && (fill_idx == IDX_W'(e));
    assign asid_now = sel ? fill_asid : asid_q;
    // flush is applied after a same-cycle install (flush wins)
    assign kill     = flush_all || (flush_asid_en && (asid_now == flush_asid));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        vpn_q  <= '0;
        asid_q <= '0;
        pfn_q  <= '0;
      end else begin
        v_q <= (sel || v_q) && !kill;
        if (sel) begin
          vpn_q  <= fill_vpn;
          asid_q <= fill_asid;
          pfn_q  <= fill_pfn;
        end
      end
    end

    assign match_vec[e] = v_q && (vpn_q == lk_vpn) && (asid_q == lk_asid);
    assign valid_vec[e] = v_q;
    assign pfn_pick[e]  = match_vec[e] ? pfn_q : '0;
  end

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_pfn = hit_pfn | pfn_pick[i];
    end
  end

endmodule

// File: rtl/xc_rr_ptr.sv
module xc_rr_ptr #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= step(ptr);
  end

endmodule

// File: rtl/xc_walk_ctl.sv
module xc_walk_ctl
  import xc_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VPN_W-1:0]  start_vpn,
  input  logic [ASID_W-1:0] start_asid,
  input  logic              walk_done,
  input  logic              walk_pte_valid,
  input  logic [PFN_W-1:0]  walk_pfn,
  output logic              idle,
  output logic              walk_req,
  output logic [VPN_W-1:0]  walk_vpn,
  output logic [ASID_W-1:0] walk_asid,
  output logic              fill_en,
  output logic [PFN_W-1:0]  fill_pfn,
  output logic              fault
);

  walk_state_e       st_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic              fault_q;
  logic              resp;

  assign resp = (st_q == WS_WALK) && walk_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WS_IDLE;
      vpn_q   <= '0;
      asid_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= resp && !walk_pte_valid;
      unique case (st_q)
        WS_IDLE: if (start) begin
          st_q   <= WS_WALK;
          vpn_q  <= start_vpn;
          asid_q <= start_asid;
        end
        WS_WALK: if (walk_done) st_q <= WS_IDLE;
        default: st_q <= WS_IDLE;
      endcase
    end
  end

  assign idle      = (st_q == WS_IDLE);
  assign walk_req  = (st_q == WS_WALK);
  assign walk_vpn  = vpn_q;
  assign walk_asid = asid_q;
  assign fill_en   = resp && walk_pte_valid;
  assign fill_pfn  = walk_pfn;
  assign fault     = fault_q;

endmodule

// File: rtl/xc_counters.sv
module xc_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_ev,
  input  logic             miss_ev,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic ev);
    return ev ? c + 1'b1 : c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      hit_count  <= bump(hit_count, hit_ev);
      miss_count <= bump(miss_count, miss_ev);
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int CNT_W   = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input  logic [ASID_W-1:0]      lk_asid,
  output logic                   lk_ready,
  output logic                   lk_hit,
  output logic [PFN_W+OFF_W-1:0] lk_paddr,
  output logic                   lk_fault,
  output logic                   walk_req,
  output logic [VPN_W-1:0]       walk_vpn,
  output logic [ASID_W-1:0]      walk_asid,
  input  logic                   walk_done,
  input  logic                   walk_pte_valid,
  input  logic [PFN_W-1:0]       walk_pfn,
  input  logic                   flush_all,
  input  logic                   flush_asid_en,
  input  logic [ASID_W-1:0]      flush_asid,
  output logic [CNT_W-1:0]       hit_count,
  output logic [CNT_W-1:0]       miss_count
);

  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_paddr(input logic [PFN_W-1:0] f,
                                                 input logic [OFF_W-1:0] o);
    return {f, o};
  endfunction

  // named internal events (observed by the checker)
  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [PFN_W-1:0]   hit_pfn;
  logic               any_match;
  logic               miss_start;
  logic               fill_en;
  logic [PFN_W-1:0]   fill_pfn;
  logic [IDX_W-1:0]   rr_ptr;
  logic               walk_idle;

  assign lk_vpn     = page_of(lk_vaddr);
  assign lk_off     = offset_of(lk_vaddr);
  assign any_match  = |match_vec;
  assign lk_ready   = walk_idle && !lk_fault;
  assign lk_hit     = lk_valid && lk_ready && any_match;
  assign miss_start = lk_valid && lk_ready && !any_match;
  assign lk_paddr   = join_paddr(hit_pfn, lk_off);

  xc_tag_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
  ) u_tags (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_vpn       (lk_vpn),
    .lk_asid      (lk_asid),
    .fill_en      (fill_en),
    .fill_idx     (rr_ptr),
    .fill_vpn     (walk_vpn),
    .fill_asid    (walk_asid),
    .fill_pfn     (fill_pfn),
    .flush_all    (flush_all),
    .flush_asid_en(flush_asid_en),
    .flush_asid   (flush_asid),
    .match_vec    (match_vec),
    .valid_vec    (valid_vec),
    .hit_pfn      (hit_pfn)
  );

  xc_rr_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rr (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(fill_en),
    .ptr    (rr_ptr)
  );

  xc_walk_ctl #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (miss_start),
    .start_vpn     (lk_vpn),
    .start_asid    (lk_asid),
    .walk_done     (walk_done),
    .walk_pte_valid(walk_pte_valid),
    .walk_pfn      (walk_pfn),
    .idle          (walk_idle),
    .walk_req      (walk_req),
    .walk_vpn      (walk_vpn),
    .walk_asid     (walk_asid),
    .fill_en       (fill_en),
    .fill_pfn      (fill_pfn),
    .fault         (lk_fault)
  );

  xc_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_ev    (lk_hit),
    .miss_ev   (miss_start),
    .hit_count (hit_count),
    .miss_count(miss_count)
  );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_ready,
  input logic               lk_hit,
  input logic               lk_fault,
  input logic               walk_req,
  input logic               walk_done,
  input logic               walk_pte_valid,
  input logic [VPN_W-1:0]   walk_vpn,
  input logic [ASID_W-1:0]  walk_asid,
  input logic               flush_all,
  input logic [ENTRIES-1:0] match_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic               fill_en,
  input logic [IDX_W-1:0]   rr_ptr,
  input logic [CNT_W-1:0]   hit_count,
  input logic [CNT_W-1:0]   miss_count
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R12

  AST_MISS_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && !lk_hit) |=> walk_req); // R3

  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_done) |=> (walk_req && $stable(walk_vpn) && $stable(walk_asid))); // R3

  AST_WALK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !lk_ready); // R3

  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> $past(walk_req && walk_done && !walk_pte_valid)); // R5

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |=> !lk_fault); // R5

  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (rr_ptr == (($past(rr_ptr) == LAST) ? '0 : $past(rr_ptr) + 1'b1))); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0)); // R7

  AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |=> (hit_count == $past(hit_count) + 1'b1)); // R9

  AST_MISS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && !lk_hit) |=> (miss_count == $past(miss_count) + 1'b1)); // R9

endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W), .ASID_W(ASID_W), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_valid      (lk_valid),
  .lk_ready      (lk_ready),
  .lk_hit        (lk_hit),
  .lk_fault      (lk_fault),
  .walk_req      (walk_req),
  .walk_done     (walk_done),
  .walk_pte_valid(walk_pte_valid),
  .walk_vpn      (walk_vpn),
  .walk_asid     (walk_asid),
  .flush_all     (flush_all),
  .match_vec     (match_vec),
  .valid_vec     (valid_vec),
  .fill_en       (fill_en),
  .rr_ptr        (rr_ptr),
  .hit_count     (hit_count),
  .miss_count    (miss_count)
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;

  localparam int E = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_ready, lk_hit, lk_fault, walk_req;
  logic [31:0] lk_paddr;
  logic [19:0] walk_vpn;
  logic [7:0]  walk_asid;
  logic        walk_done = 1'b0;
  logic        walk_pte_valid = 1'b0;
  logic [19:0] walk_pfn = '0;
  logic        fl_all_t = 1'b0;
  logic        fl_all_w = 1'b0;
  logic        flush_all;
  logic        flush_asid_en = 1'b0;
  logic [7:0]  flush_asid = '0;
  logic [31:0] hit_count, miss_count;

  assign flush_all = fl_all_t | fl_all_w;

  always #5 clk = ~clk;

  xlat_cache #(.ENTRIES(E)) u_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_ready(lk_ready), .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_fault(lk_fault),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_asid(walk_asid), .walk_done(walk_done),
    .walk_pte_valid(walk_pte_valid), .walk_pfn(walk_pfn), .flush_all(flush_all),
    .flush_asid_en(flush_asid_en), .flush_asid(flush_asid),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  int n_chk = 0;
  int n_bad = 0;
  int exp_hits = 0;
  int exp_misses = 0;
  bit flush_on_done = 1'b0;

  // reference contents
  bit          m_v    [E];
  logic [19:0] m_vpn  [E];
  logic [7:0]  m_asid [E];
  logic [19:0] m_pfn  [E];
  int          m_ptr = 0;

  typedef struct packed { logic [19:0] vpn; logic [7:0] asid; } walk_item_t;
  walk_item_t exp_q[$];

  function automatic logic [19:0] pt_frame(input logic [19:0] v, input logic [7:0] a);
    return v ^ {a, 12'h3C5};
  endfunction

  function automatic bit pt_ok(input logic [19:0] v);
    return v[19:16] != 4'hF;
  endfunction

  function automatic int ref_find(input logic [19:0] v, input logic [7:0] a);
    for (int i = 0; i < E; i++) if (m_v[i] && m_vpn[i] == v && m_asid[i] == a) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // driver: one lookup, resolving any miss through the walker model
  task automatic access(input logic [19:0] v, input logic [11:0] o,
                        input logic [7:0] a, input string tag);
    int idx;
    @(negedge clk);
    lk_vaddr = {v, o}; lk_asid = a; lk_valid = 1'b1;
    #1;
    idx = ref_find(v, a);
    if (idx >= 0) begin
      check(lk_hit === 1'b1, tag, "hit", 64'(lk_hit), 64'd1);
      check(lk_paddr === {m_pfn[idx], o}, tag, "paddr", 64'(lk_paddr), 64'({m_pfn[idx], o}));
      exp_hits++;
      @(negedge clk);
      lk_valid = 1'b0;
    end else begin
      check(lk_hit === 1'b0, tag, "miss", 64'(lk_hit), 64'd0);
      exp_q.push_back('{vpn: v, asid: a});
      exp_misses++;
      @(negedge clk);
      while (!lk_ready && !lk_fault) begin
        check(walk_req === 1'b1, "R3", "walk_req held", 64'(walk_req), 64'd1);
        @(negedge clk);
      end
      if (pt_ok(v)) begin
        m_v[m_ptr] = 1'b1; m_vpn[m_ptr] = v; m_asid[m_ptr] = a; m_pfn[m_ptr] = pt_frame(v, a);
        m_ptr = (m_ptr + 1) % E;
        if (flush_on_done) begin
          for (int i = 0; i < E; i++) m_v[i] = 1'b0;
          flush_on_done = 1'b0;
          check(lk_hit === 1'b0, "R11", "flushed install", 64'(lk_hit), 64'd0);
          lk_valid = 1'b0;
        end else begin
          check(lk_hit === 1'b1, "R4", "hit after install", 64'(lk_hit), 64'd1);
          check(lk_paddr === {pt_frame(v, a), o}, "R4", "paddr after install",
                64'(lk_paddr), 64'({pt_frame(v, a), o}));
          exp_hits++;
          @(negedge clk);
          lk_valid = 1'b0;
        end
      end else begin
        check(lk_fault === 1'b1 && lk_ready === 1'b0, "R5", "fault",
              64'({lk_fault, lk_ready}), 64'b10);
        lk_valid = 1'b0;
        @(negedge clk);
        check(lk_fault === 1'b0, "R5", "fault one cycle", 64'(lk_fault), 64'd0);
      end
    end
  endtask

  task automatic do_flush_all();
    @(negedge clk);
    fl_all_t = 1'b1;
    for (int i = 0; i < E; i++) m_v[i] = 1'b0;
    @(negedge clk);
    fl_all_t = 1'b0;
  endtask

  task automatic do_flush_asid(input logic [7:0] a);
    @(negedge clk);
    flush_asid_en = 1'b1; flush_asid = a;
    for (int i = 0; i < E; i++) if (m_asid[i] == a) m_v[i] = 1'b0;
    @(negedge clk);
    flush_asid_en = 1'b0;
  endtask

  // monitor: walker model and scoreboard of walk requests
  initial begin
    walk_item_t it;
    forever begin
      @(negedge clk);
      if (rst_n && walk_req === 1'b1 && !walk_done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected walk", 64'(walk_vpn), 64'd0);
        end else begin
          it = exp_q.pop_front();
          check(walk_vpn === it.vpn && walk_asid === it.asid, "R3", "walk target",
                64'({walk_vpn, walk_asid}), 64'({it.vpn, it.asid}));
        end
        repeat (2) @(negedge clk);
        walk_done = 1'b1;
        walk_pte_valid = pt_ok(walk_vpn);
        walk_pfn = pt_frame(walk_vpn, walk_asid);
        if (flush_on_done) fl_all_w = 1'b1;
        @(negedge clk);
        walk_done = 1'b0;
        fl_all_w = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < E; i++) m_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(lk_ready === 1'b1, "R10", "ready", 64'(lk_ready), 64'd1);
    check(walk_req === 1'b0 && lk_fault === 1'b0, "R10", "idle outputs",
          64'({walk_req, lk_fault}), 64'd0);
    check(hit_count === 0 && miss_count === 0, "R10", "counters",
          64'({hit_count, miss_count}), 64'd0);

    access(20'h00010, 12'h123, 8'd1, "R4");
    access(20'h00010, 12'hABC, 8'd1, "R1");
    access(20'h00010, 12'h001, 8'd2, "R2");   // same page, other space: miss
    access(20'h00010, 12'hFFF, 8'd1, "R1");
    access(20'h00010, 12'h007, 8'd2, "R2");
    access(20'hF0001, 12'h000, 8'd1, "R5");   // not present
    access(20'hF0001, 12'h004, 8'd1, "R5");   // still not installed
    @(negedge clk);
    check(hit_count === 32'(exp_hits), "R9", "hit count mid", 64'(hit_count), 64'(exp_hits));

    // fill and wrap the four slots
    access(20'h00020, 12'h010, 8'd1, "R6");
    access(20'h00030, 12'h020, 8'd2, "R6");
    access(20'h00040, 12'h030, 8'd1, "R6");   // evicts slot 0
    access(20'h00010, 12'h040, 8'd1, "R6");   // evicted, reinstalled in slot 1
    access(20'h00010, 12'h050, 8'd2, "R6");   // evicted, reinstalled in slot 2
    access(20'h00030, 12'h060, 8'd2, "R6");   // slot 3 still present

    do_flush_asid(8'd1);
    access(20'h00030, 12'h070, 8'd2, "R8");
    access(20'h00040, 12'h080, 8'd1, "R8");
    access(20'h00010, 12'h090, 8'd2, "R8");

    do_flush_all();
    access(20'h00010, 12'h0A0, 8'd2, "R7");
    access(20'h00030, 12'h0B0, 8'd2, "R7");

    flush_on_done = 1'b1;
    access(20'h00050, 12'h0C0, 8'd3, "R11");
    access(20'h00050, 12'h0D0, 8'd3, "R11");
    access(20'h00050, 12'h0E0, 8'd3, "R1");

    @(negedge clk);
    check(hit_count === 32'(exp_hits), "R9", "hit count", 64'(hit_count), 64'(exp_hits));
    check(miss_count === 32'(exp_misses), "R9", "miss count", 64'(miss_count), 64'(exp_misses));
    check(exp_q.size() == 0, "R3", "walks consumed", 64'(exp_q.size()), 64'd0);

    summary();
    $finish;
  end

endmodule